// File: doc/BRIEF.md
# Fixed-Point Operand Routing Unit

This unit evaluates the thirty-two fixed-point register/store functions of a single-accumulator machine in one combinational pass. From a 6-bit function code, the current accumulator word and the addressed store word, it produces the accumulator value and the store value that the function leaves behind, together with a store write strobe. The function code splits into two parts. One part picks one of eight arithmetic or logical operations. The other picks one of four ways of routing the operand and the result between the accumulator and the store.

The execution sequencer drives `issue` high for exactly one clock cycle when a function is to take effect. In that cycle it captures `accNext` and `memNext` and honours `memWe`. Arithmetic overflow collects in a sticky flag held in the unit. The flag stays set until the sequencer pulses `ovClear`. Memory timing, jumps, shifts and multiply/divide are handled elsewhere.

Top module: `fxu_route_unit`

## Requirements
- R1: The function code is decoded as follows. `fnCode[5]` must be 0 for a valid function. The routing group is `fnCode[4:3]` and the operation is `fnCode[2:0]`. When `fnCode[5]` is 1, `accNext` equals `accIn`, `memNext` equals `memIn`, `memWe` is 0 and the overflow flag is not set.
- R2: All arithmetic is 39-bit two's complement. The operation codes are: 0 = x, 1 = -x, 2 = n+1, 3 = a AND n (bitwise), 4 = a+n, 5 = a-n, 6 = zero, 7 = n-a. Here a is `accIn` and n is `memIn`. The operand x is a in groups 0 and 2, and n in groups 1 and 3.
- R3: Group 0 routes the result to `accNext`. `memNext` equals `memIn`.
- R4: Group 1 routes the result to `accNext`. `memNext` equals `accIn`.
- R5: Group 2 routes the result to `memNext`. `accNext` equals `accIn`.
- R6: Group 3 routes the result to `memNext`. `accNext` equals `memIn`.
- R7: `memWe` is 1 exactly when `issue` is 1, `fnCode[5]` is 0 and the group is 1, 2 or 3. It is never 1 for group 0.
- R8: The overflow flag `ovFlag` is set on the rising clock edge that ends an `issue` cycle when the true result of an operation 1, 2, 4, 5 or 7 lies outside [-2^38, 2^38-1]. A cycle without `issue` never sets it.
- R9: Negating the most negative value (only bit 38 set) returns that same bit pattern and sets the overflow flag.
- R10: Operations 0, 3 and 6 never set the overflow flag, whatever the operand values.
- R11: `ovFlag` is 0 after reset and holds once set. A clock edge with `ovClear` high clears it, unless the same edge sets it under R8, in which case setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Function takes effect this cycle |
| ovClear | input | 1 | Clear the sticky overflow flag |
| fnCode | input | 6 | Function code: bit 5 invalid marker, bits 4:3 group, bits 2:0 operation |
| accIn | input | 39 | Current accumulator word |
| memIn | input | 39 | Current addressed store word |
| accNext | output | 39 | Accumulator value after the function |
| memNext | output | 39 | Store value after the function |
| memWe | output | 1 | Store write strobe |
| ovFlag | output | 1 | Sticky overflow flag |

## Verification
The clocked properties assume that `fnCode`, `accIn`, `memIn`, `issue` and `ovClear` stay stable around each rising edge. They also assume that `issue` is low while reset is held, so a rise of the overflow flag can always be traced back to an issued function. The bench meets both assumptions. It changes every input only on the falling edge and keeps `issue` and `ovClear` low throughout reset. It holds `ovFlag` clear before each collate check, so that check compares against a known starting state.

// File: rtl/fxu_pkg.sv
package fxu_pkg;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_NEG  = 3'd1,
    OP_INC  = 3'd2,
    OP_AND  = 3'd3,
    OP_ADD  = 3'd4,
    OP_SUB  = 3'd5,
    OP_ZERO = 3'd6,
    OP_RSUB = 3'd7
  } opKind_e;

  typedef enum logic [1:0] {
    ACC_FROM_RES = 2'd0,
    ACC_FROM_OLD = 2'd1,
    ACC_FROM_MEM = 2'd2
  } accSrc_e;

  typedef enum logic [1:0] {
    MEM_FROM_OLD = 2'd0,
    MEM_FROM_ACC = 2'd1,
    MEM_FROM_RES = 2'd2
  } memSrc_e;

  typedef struct packed {
    opKind_e op;
    logic    xFromMem;
    accSrc_e accSel;
    memSrc_e memSel;
    logic    memWr;
    logic    ovArm;
  } ctrlStrobes_t;

endpackage

// File: rtl/fxu_ctrl.sv
module fxu_ctrl
  import fxu_pkg::*;
#(
  parameter int FN_W = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            issue,
  input  logic            ovClear,
  input  logic [FN_W-1:0] fnCode,
  input  logic            ovEvent,
  output ctrlStrobes_t    strobes,
  output logic            ovFlag
);

  localparam int GRP_LO = FN_W - 3;

  logic       fnValid;
  logic [1:0] grp;

  assign fnValid = !fnCode[FN_W-1];
  assign grp     = fnCode[GRP_LO+1:GRP_LO];

  always_comb begin
    strobes.op       = opKind_e'(fnCode[2:0]);
    strobes.xFromMem = 1'b0;
    strobes.accSel   = ACC_FROM_OLD;
    strobes.memSel   = MEM_FROM_OLD;
    strobes.memWr    = 1'b0;
    strobes.ovArm    = issue && fnValid;
    if (fnValid) begin
      unique case (grp)
        2'd0: begin
          strobes.accSel = ACC_FROM_RES;
        end
        2'd1: begin
          strobes.xFromMem = 1'b1;
          strobes.accSel   = ACC_FROM_RES;
          strobes.memSel   = MEM_FROM_ACC;
          strobes.memWr    = issue;
        end
        2'd2: begin
          strobes.memSel = MEM_FROM_RES;
          strobes.memWr  = issue;
        end
        default: begin
          strobes.xFromMem = 1'b1;
          strobes.accSel   = ACC_FROM_MEM;
          strobes.memSel   = MEM_FROM_RES;
          strobes.memWr    = issue;
        end
      endcase
    end
  end

  // Sticky overflow: a new overflow takes priority over a clear on the same edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovFlag <= 1'b0;
    end else if (strobes.ovArm && ovEvent) begin
      ovFlag <= 1'b1;
    end else if (ovClear) begin
      ovFlag <= 1'b0;
    end
  end

  p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    ovFlag && !ovClear |=> ovFlag);

  p_clear_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    ovClear && !issue |=> !ovFlag);

  p_rise_needs_issue_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovFlag) |-> $past(issue));

endmodule

// File: rtl/fxu_datapath.sv
module fxu_datapath
  import fxu_pkg::*;
#(
  parameter int WIDTH = 39
) (
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] memIn,
  output logic [WIDTH-1:0] accNext,
  output logic [WIDTH-1:0] memNext,
  output logic             ovEvent
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] xVal;
  logic [WIDTH-1:0] addA;
  logic [WIDTH-1:0] addB;
  logic             carryIn;
  logic             isArith;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] result;

  assign xVal = strobes.xFromMem ? memIn : accIn;

  // One shared adder serves every arithmetic operation through operand muxing.
  always_comb begin
    addA    = '0;
    addB    = '0;
    carryIn = 1'b0;
    isArith = 1'b0;
    unique case (strobes.op)
      OP_NEG:  begin addB = ~xVal;                 carryIn = 1'b1; isArith = 1'b1; end
      OP_INC:  begin addA = memIn;                 carryIn = 1'b1; isArith = 1'b1; end
      OP_ADD:  begin addA = accIn; addB = memIn;                   isArith = 1'b1; end
      OP_SUB:  begin addA = accIn; addB = ~memIn;  carryIn = 1'b1; isArith = 1'b1; end
      OP_RSUB: begin addA = memIn; addB = ~accIn;  carryIn = 1'b1; isArith = 1'b1; end
      default: ;
    endcase
  end

  assign sum = addA + addB + {{(WIDTH-1){1'b0}}, carryIn};

  assign ovEvent = isArith && (addA[MSB] == addB[MSB]) && (sum[MSB] != addA[MSB]);

  always_comb begin
    unique case (strobes.op)
      OP_PASS: result = xVal;
      OP_AND:  result = accIn & memIn;
      OP_ZERO: result = '0;
      default: result = sum;
    endcase
  end

  always_comb begin
    unique case (strobes.accSel)
      ACC_FROM_RES: accNext = result;
      ACC_FROM_MEM: accNext = memIn;
      default:      accNext = accIn;
    endcase
    unique case (strobes.memSel)
      MEM_FROM_RES: memNext = result;
      MEM_FROM_ACC: memNext = accIn;
      default:      memNext = memIn;
    endcase
  end

endmodule

// File: rtl/fxu_route_unit.sv
module fxu_route_unit
  import fxu_pkg::*;
#(
  parameter int WIDTH = 39
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issue,
  input  logic             ovClear,
  input  logic [5:0]       fnCode,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] memIn,
  output logic [WIDTH-1:0] accNext,
  output logic [WIDTH-1:0] memNext,
  output logic             memWe,
  output logic             ovFlag
);

  localparam int FN_W = 6;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  ctrlStrobes_t strobes;
  logic         ovEvent;

  fxu_ctrl #(.FN_W(FN_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .issue   (issue),
    .ovClear (ovClear),
    .fnCode  (fnCode),
    .ovEvent (ovEvent),
    .strobes (strobes),
    .ovFlag  (ovFlag)
  );

  fxu_datapath #(.WIDTH(WIDTH)) uPath (
    .strobes (strobes),
    .accIn   (accIn),
    .memIn   (memIn),
    .accNext (accNext),
    .memNext (memNext),
    .ovEvent (ovEvent)
  );

  assign memWe = strobes.memWr;

  p_invalid_noop_r1: assert property (@(posedge clk) disable iff (!rstN)
    fnCode[5] |-> (accNext == accIn) && (memNext == memIn) && !memWe);

  p_group0_store_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    fnCode[5:3] == 3'd0 |-> memNext == memIn);

  p_group2_acc_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    fnCode[5:3] == 3'd2 |-> accNext == accIn);

  p_no_write_group0_r7: assert property (@(posedge clk) disable iff (!rstN)
    fnCode[5:3] == 3'd0 |-> !memWe);

  p_neg_most_neg_r9: assert property (@(posedge clk) disable iff (!rstN)
    fnCode == 6'o01 && accIn == MOST_NEG |-> accNext == MOST_NEG);

  p_collate_no_ovf_r10: assert property (@(posedge clk) disable iff (!rstN)
    issue && !fnCode[5] && fnCode[2:0] == 3'd3 && !ovFlag && !ovClear |=> !ovFlag);

endmodule

// File: tb/tb_fxu_route_unit.sv
`timescale 1ns/1ps
module tb_fxu_route_unit;

  localparam int W = 39;
  localparam longint MAXV = (64'sd1 <<< 38) - 1;
  localparam longint MINV = -(64'sd1 <<< 38);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issue = 1'b0;
  logic ovClear = 1'b0;
  logic [5:0] fnCode = 6'o00;
  logic [W-1:0] accIn = '0;
  logic [W-1:0] memIn = '0;
  logic [W-1:0] accNext, memNext;
  logic memWe, ovFlag;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic expSticky = 1'b0;

  always #10 clk = ~clk;

  fxu_route_unit dut (
    .clk(clk), .rstN(rstN), .issue(issue), .ovClear(ovClear), .fnCode(fnCode),
    .accIn(accIn), .memIn(memIn), .accNext(accNext), .memNext(memNext),
    .memWe(memWe), .ovFlag(ovFlag)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s fn=%o actual=%h expected=%h", req, fnCode, act, exp);
    end
  endtask

  function automatic longint sx(logic [W-1:0] v);
    return longint'({{(64-W){v[W-1]}}, v});
  endfunction

  // Independent reference built from R2..R8 using wide signed arithmetic.
  task automatic refModel(input logic [5:0] fn, input logic [W-1:0] a, input logic [W-1:0] n,
                          output logic [W-1:0] eAcc, output logic [W-1:0] eMem,
                          output logic eWe, output logic eOv);
    longint v;
    logic [W-1:0] r;
    logic [W-1:0] x;
    int grp = int'(fn[4:3]);
    x = (grp == 1 || grp == 3) ? n : a;
    eOv = 1'b0;
    v = 0;
    case (fn[2:0])
      3'd0: v = sx(x);
      3'd1: v = -sx(x);
      3'd2: v = sx(n) + 1;
      3'd4: v = sx(a) + sx(n);
      3'd5: v = sx(a) - sx(n);
      3'd7: v = sx(n) - sx(a);
      default: v = 0;
    endcase
    r = v[W-1:0];
    if (fn[2:0] == 3'd3) r = a & n;
    if (fn[2:0] inside {3'd1, 3'd2, 3'd4, 3'd5, 3'd7}) eOv = (v > MAXV) || (v < MINV);
    if (fn[5]) begin
      eAcc = a; eMem = n; eWe = 1'b0; eOv = 1'b0;
    end else begin
      case (grp)
        0: begin eAcc = r; eMem = n; end
        1: begin eAcc = r; eMem = a; end
        2: begin eAcc = a; eMem = r; end
        default: begin eAcc = n; eMem = r; end
      endcase
      eWe = (grp != 0);
    end
  endtask

  task automatic applyOp(string req, logic [5:0] fn, logic [W-1:0] a, logic [W-1:0] n);
    logic [W-1:0] eAcc, eMem;
    logic eWe, eOv;
    @(negedge clk);
    fnCode = fn; accIn = a; memIn = n; issue = 1'b1; ovClear = 1'b0;
    refModel(fn, a, n, eAcc, eMem, eWe, eOv);
    #2;
    chk({req, " acc"}, accNext, eAcc);
    chk({req, " mem"}, memNext, eMem);
    chk({req, " we"}, {{(W-1){1'b0}}, memWe}, {{(W-1){1'b0}}, eWe});
    @(negedge clk);
    issue = 1'b0;
    expSticky = expSticky | eOv;
    chk({req, " ovf"}, {{(W-1){1'b0}}, ovFlag}, {{(W-1){1'b0}}, expSticky});
  endtask

  task automatic clearOv();
    @(negedge clk);
    ovClear = 1'b1;
    @(negedge clk);
    ovClear = 1'b0;
    expSticky = 1'b0;
    chk("R11 clear", {{(W-1){1'b0}}, ovFlag}, '0);
  endtask

  task automatic tResetState();
    chk("R11 reset ovf", {{(W-1){1'b0}}, ovFlag}, '0);
    chk("R7 reset we", {{(W-1){1'b0}}, memWe}, '0);
  endtask

  task automatic tGroupSweep(int grp, string req);
    logic [W-1:0] pa [4] = '{39'h00_0000_1234, 39'h7F_FFFF_FFF0, 39'h12_3456_789A, 39'h00_0000_0000};
    logic [W-1:0] pn [4] = '{39'h00_0000_0042, 39'h00_0000_0001, 39'h55_5555_5555, 39'h3F_FFFF_FFFF};
    for (int p = 0; p < 4; p++) begin
      for (int op = 0; op < 8; op++) begin
        applyOp(req, {1'b0, 2'(grp), 3'(op)}, pa[p], pn[p]);
        clearOv();
      end
    end
  endtask

  task automatic tOverflow();
    applyOp("R8 add pos", 6'o04, MOST_POS, 39'd1);
    clearOv();
    applyOp("R8 sub", 6'o05, 39'd0, MOST_NEG);
    clearOv();
    applyOp("R8 inc", 6'o02, 39'd5, MOST_POS);
    clearOv();
    applyOp("R8 rsub", 6'o07, MOST_POS, MOST_NEG);
    clearOv();
    applyOp("R8 add neg", 6'o04, MOST_NEG, MOST_NEG);
    clearOv();
    applyOp("R8 no ovf", 6'o05, MOST_NEG, 39'd0);
    // issue low: a would-be overflow must not set the flag
    @(negedge clk);
    fnCode = 6'o04; accIn = MOST_POS; memIn = MOST_POS; issue = 1'b0;
    @(negedge clk);
    chk("R8 idle no ovf", {{(W-1){1'b0}}, ovFlag}, '0);
    chk("R7 idle no we", {{(W-1){1'b0}}, memWe}, '0);
  endtask

  task automatic tNegMin();
    applyOp("R9 neg acc", 6'o01, MOST_NEG, 39'd7);
    chk("R9 pattern kept", accNext, MOST_NEG);
    clearOv();
    applyOp("R9 neg store", 6'o31, 39'd3, MOST_NEG);
    clearOv();
  endtask

  task automatic tNoOvfOps();
    applyOp("R10 collate", 6'o03, MOST_NEG, MOST_NEG);
    applyOp("R10 pass", 6'o10, MOST_POS, MOST_NEG);
    applyOp("R10 zero", 6'o26, MOST_NEG, MOST_POS);
    applyOp("R10 collate store", 6'o33, MOST_POS, MOST_POS);
  endtask

  task automatic tSticky();
    applyOp("R11 set", 6'o04, MOST_POS, MOST_POS);
    applyOp("R11 hold after benign", 6'o04, 39'd1, 39'd2);
    // set wins over clear on the same edge
    @(negedge clk);
    fnCode = 6'o04; accIn = MOST_POS; memIn = 39'd1; issue = 1'b1; ovClear = 1'b1;
    @(negedge clk);
    issue = 1'b0; ovClear = 1'b0;
    chk("R11 set wins", {{(W-1){1'b0}}, ovFlag}, 39'd1);
    clearOv();
  endtask

  task automatic tInvalid();
    applyOp("R1 invalid add", 6'o44, MOST_POS, MOST_POS);
    applyOp("R1 invalid store", 6'o64, 39'h12345, 39'h54321);
    applyOp("R1 invalid neg", 6'o71, MOST_NEG, MOST_NEG);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tResetState();
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tGroupSweep(0, "R2 R3 group0");
    tGroupSweep(1, "R2 R4 group1");
    tGroupSweep(2, "R2 R5 group2");
    tGroupSweep(3, "R2 R6 group3");
    tOverflow();
    tNegMin();
    tNoOvfOps();
    tSticky();
    tInvalid();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule